// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiply Unit

This block multiplies two 8-bit operands and returns a 16-bit product exactly two clock cycles after a start strobe. A 3-bit operation select picks how each operand is read: unsigned, two's complement, or mixed (first operand signed, second unsigned). It also picks whether the result is left in integer form or in fractional form. The fractional form shifts the product left by one bit.

The unit sits beside a processor datapath. The caller raises the start strobe for one cycle with the operands and the select. It then receives the high and low product bytes, a zero flag and a carry flag, together with a one-cycle done pulse. Write-back, decode and stall control stay with the caller. The outputs hold their last completed value until the next operation completes.

The select encoding is as follows. Bit 2 selects the fractional form. Bits 1:0 select the sign mode: 00 is unsigned x unsigned, 01 is signed x signed, 10 is signed x unsigned, and 11 is handled as unsigned.

Top module: `mul8_two_cycle`

## Requirements
- R1: With op bits 1:0 = 00, both operands are read as unsigned and {prod_hi_o, prod_lo_o} is the low 16 bits of their product.
- R2: With op bits 1:0 = 01, both operands are read as two's complement and the 16-bit product is the two's complement result.
- R3: With op bits 1:0 = 10, opa_i is read as two's complement and opb_i as unsigned.
- R4: With op bit 2 = 1, the delivered 16-bit result is the raw product shifted left by one, with the top bit dropped and bit 0 equal to 0.
- R5: flag_c_o equals bit 15 of the raw 16-bit product, taken before any fractional shift.
- R6: flag_z_o is 1 exactly when the delivered 16-bit result (after any shift) is all zeros.
- R7: When start_i is accepted in cycle n, done_o is high for exactly one cycle, in cycle n+2, and the new result and flags are valid in that cycle.
- R8: A start_i seen in the cycle right after an accepted start (while busy) is ignored. It produces no extra done and does not change the pending result.
- R9: Product and flags hold their last completed value between completions. Synchronous active-high rst clears product, flags, done and busy state.
- R10: Op bits 1:0 = 11 behave exactly as unsigned x unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a multiply |
| op_i | input | 3 | Bit 2 selects fractional form; bits 1:0 select the sign mode |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| flag_z_o | output | 1 | Result-is-zero flag |
| flag_c_o | output | 1 | Raw product bit 15 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The operand 0xFF against 0xFF is applied under every sign mode. The three results (0xFE01, 0x0001, 0xFF01) show which operand received sign extension, and the reserved code must match the unsigned one. The pair -128 x -128 in fractional form tells the raw-bit-15 carry apart from the shifted result's top bit, and zero operands exercise the zero flag in both forms. A back-to-back start pair and a long pseudo-random sequence with random idle gaps check latency, the ignore-while-busy rule and result holding.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  localparam int OPSEL_W  = 3;
  localparam int FRAC_BIT = 2;

  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_ALT = 2'b11
  } sgn_mode_e;

  typedef struct packed {
    logic      frac;
    sgn_mode_e mode;
  } opsel_t;
endpackage

// File: rtl/mul8_opnd_stage.sv
module mul8_opnd_stage
  import mul8_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [OPSEL_W-1:0]     op_i,
  input  logic [OPW-1:0]         a_i,
  input  logic [OPW-1:0]         b_i,
  output logic                   accept_o,
  output logic                   busy_o,
  output logic                   frac_o,
  output logic signed [OPW:0]    ext_a_o,
  output logic signed [OPW:0]    ext_b_o
);
  // first operand is signed in the signed and mixed modes
  function automatic logic a_signed(input sgn_mode_e m);
    return (m == SGN_SS) || (m == SGN_SU);
  endfunction

  // second operand is signed only in the fully signed mode
  function automatic logic b_signed(input sgn_mode_e m);
    return (m == SGN_SS);
  endfunction

  function automatic logic signed [OPW:0] widen(input logic [OPW-1:0] v, input logic sgn);
    return $signed({sgn & v[OPW-1], v});
  endfunction

  opsel_t sel;
  logic   busy_q;

  assign sel      = opsel_t'(op_i);
  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      frac_o  <= 1'b0;
      ext_a_o <= '0;
      ext_b_o <= '0;
    end else if (accept_o) begin
      busy_q  <= 1'b1;
      frac_o  <= sel.frac;
      ext_a_o <= widen(a_i, a_signed(sel.mode));
      ext_b_o <= widen(b_i, b_signed(sel.mode));
    end else begin
      busy_q  <= 1'b0;
    end
  end

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> busy_q);
  // R7
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
  // R8
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(ext_a_o) && $stable(ext_b_o) && $stable(frac_o)));
endmodule

// File: rtl/mul8_array.sv
module mul8_array #(
  parameter int OPW = 8
) (
  input  logic signed [OPW:0]   ea_i,
  input  logic signed [OPW:0]   eb_i,
  output logic [2*OPW-1:0]      raw_o
);
  localparam int FULL_W = 2*OPW + 2;

  function automatic logic signed [FULL_W-1:0] smul(input logic signed [OPW:0] x,
                                                    input logic signed [OPW:0] y);
    return FULL_W'(x) * FULL_W'(y);
  endfunction

  logic signed [FULL_W-1:0] full_prod;

  assign full_prod = smul(ea_i, eb_i);
  assign raw_o     = full_prod[2*OPW-1:0];

  logic unused_top;
  assign unused_top = ^full_prod[FULL_W-1:2*OPW];
endmodule

// File: rtl/mul8_result_stage.sv
module mul8_result_stage #(
  parameter int OPW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               frac_i,
  input  logic [2*OPW-1:0]   raw_i,
  output logic [2*OPW-1:0]   prod_o,
  output logic               zero_o,
  output logic               carry_o,
  output logic               done_o
);
  localparam int PW = 2*OPW;

  function automatic logic [PW-1:0] align(input logic [PW-1:0] r, input logic f);
    return f ? {r[PW-2:0], 1'b0} : r;
  endfunction

  function automatic logic all_zero(input logic [PW-1:0] r);
    return (r == '0);
  endfunction

  logic [PW-1:0] final_w;
  logic          frac_last;

  assign final_w = align(raw_i, frac_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o    <= '0;
      zero_o    <= 1'b0;
      carry_o   <= 1'b0;
      done_o    <= 1'b0;
      frac_last <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        prod_o    <= final_w;
        zero_o    <= all_zero(final_w);
        carry_o   <= raw_i[PW-1];
        frac_last <= frac_i;
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (zero_o == (prod_o == '0)));
  // R4
  frac_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && frac_last) |-> (prod_o[0] == 1'b0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(prod_o) && $stable(zero_o) && $stable(carry_o)));
endmodule

// File: rtl/mul8_two_cycle.sv
module mul8_two_cycle
  import mul8_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [OPSEL_W-1:0]   op_i,
  input  logic [OPW-1:0]       opa_i,
  input  logic [OPW-1:0]       opb_i,
  output logic [OPW-1:0]       prod_hi_o,
  output logic [OPW-1:0]       prod_lo_o,
  output logic                 flag_z_o,
  output logic                 flag_c_o,
  output logic                 done_o
);
  localparam int PW = 2*OPW;

  logic                  accept_w;
  logic                  busy_w;
  logic                  frac_w;
  logic signed [OPW:0]   ext_a_w;
  logic signed [OPW:0]   ext_b_w;
  logic [PW-1:0]         raw_w;
  logic [PW-1:0]         prod_w;

  mul8_opnd_stage #(.OPW(OPW)) opnd_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .a_i(opa_i), .b_i(opb_i),
    .accept_o(accept_w), .busy_o(busy_w), .frac_o(frac_w),
    .ext_a_o(ext_a_w), .ext_b_o(ext_b_w)
  );

  mul8_array #(.OPW(OPW)) array_i (
    .ea_i(ext_a_w), .eb_i(ext_b_w), .raw_o(raw_w)
  );

  mul8_result_stage #(.OPW(OPW)) result_i (
    .clk(clk), .rst(rst), .load_i(busy_w), .frac_i(frac_w), .raw_i(raw_w),
    .prod_o(prod_w), .zero_o(flag_z_o), .carry_o(flag_c_o), .done_o(done_o)
  );

  assign prod_hi_o = prod_w[PW-1:OPW];
  assign prod_lo_o = prod_w[OPW-1:0];

  // R7
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> ##1 done_o);
  // R8
  no_done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_w |-> !done_o);
endmodule

// File: tb/mul8_two_cycle_tb_top.sv
`timescale 1ns/1ps
module mul8_two_cycle_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] opa_i = '0;
  logic [7:0] opb_i = '0;
  logic [7:0] prod_hi_o, prod_lo_o;
  logic       flag_z_o, flag_c_o, done_o;

  always #2.5 clk = ~clk;

  mul8_two_cycle dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .done_o(done_o)
  );

  typedef struct {
    logic [15:0] res;
    logic        z;
    logic        c;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // independent model: sign mode bits 1:0, fractional bit 2
  function automatic exp_t model(input logic [2:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input string tag);
    exp_t e;
    int av, bv, p;
    logic [15:0] raw;
    av = ((op[1:0] == 2'b01) || (op[1:0] == 2'b10)) ? int'($signed(a)) : int'(a);
    bv = (op[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = av * bv;
    raw = p[15:0];
    e.c = raw[15];
    e.res = op[2] ? {raw[14:0], 1'b0} : raw;
    e.z = (e.res == 16'h0);
    e.tag = tag;
    e.due = 0;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // drive a start at the current negedge; push expectation if it should be accepted
  task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input bit expect_it, input string tag);
    exp_t e;
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    if (expect_it) begin
      e = model(op, a, b, tag);
      e.due = cyc + 2;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  task automatic one(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                     input string tag);
    drive(op, a, b, 1'b1, tag);
    idle(3);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() != 0 && q[0].due < cyc) begin
        check(1'b0, "R7", $sformatf("missing done, expected at cycle %0d now %0d",
                                    q[0].due, cyc));
        void'(q.pop_front());
      end
      if (done_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "done with no pending operation (actual 1 expected 0)");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, "R7", $sformatf("done at cycle %0d expected %0d", cyc, e.due));
          check({prod_hi_o, prod_lo_o} == e.res && flag_z_o == e.z && flag_c_o == e.c,
                e.tag, $sformatf("got %h z%b c%b expected %h z%b c%b",
                                 {prod_hi_o, prod_lo_o}, flag_z_o, flag_c_o,
                                 e.res, e.z, e.c));
          last_exp = e;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check({prod_hi_o, prod_lo_o} == 16'h0 && !flag_z_o && !flag_c_o && !done_o, "R9",
          $sformatf("reset outputs %h z%b c%b d%b expected 0", {prod_hi_o, prod_lo_o},
                    flag_z_o, flag_c_o, done_o));
    rst = 1'b0;

    one(3'b000, 8'hFF, 8'hFF, "R1");   // 0xFE01, carry set (R5)
    one(3'b000, 8'h12, 8'h34, "R1");
    one(3'b001, 8'hFF, 8'hFF, "R2");   // -1*-1 = 1
    one(3'b001, 8'hFF, 8'h01, "R2");   // -1
    one(3'b010, 8'hFF, 8'hFF, "R3");   // -255 = 0xFF01
    one(3'b010, 8'h80, 8'h80, "R3");   // -16384
    one(3'b011, 8'hFF, 8'hFF, "R10");  // as unsigned
    one(3'b101, 8'h80, 8'h80, "R4");   // 0x4000 -> 0x8000, carry 0 (R5)
    one(3'b110, 8'h80, 8'h80, "R5");   // 0xC000 -> 0x8000, carry 1
    one(3'b100, 8'hFF, 8'hFF, "R4");
    one(3'b000, 8'h00, 8'h55, "R6");
    one(3'b101, 8'h00, 8'hAA, "R6");

    // R8: second start one cycle later is ignored
    drive(3'b000, 8'h03, 8'h05, 1'b1, "R8");
    drive(3'b001, 8'h7F, 8'h7F, 1'b0, "R8");
    idle(4);

    // R9: hold after completion
    check({prod_hi_o, prod_lo_o} == last_exp.res && flag_z_o == last_exp.z &&
          flag_c_o == last_exp.c && !done_o, "R9",
          $sformatf("held %h expected %h", {prod_hi_o, prod_lo_o}, last_exp.res));

    // pseudo-random with back-to-back and gaps
    for (int k = 0; k < 300; k++) begin
      logic [2:0] op;
      lfsr = step(lfsr);
      op = lfsr[2:0];
      drive(op, lfsr[15:8], lfsr[10:3], 1'b1,
            (op[2] ? "R4" : (op[1:0] == 2'b00 ? "R1" : (op[1:0] == 2'b01 ? "R2" :
             (op[1:0] == 2'b10 ? "R3" : "R10")))));
      idle(1 + int'(lfsr[11]));
    end
    idle(4);

    // R9 mid-run reset clears result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check({prod_hi_o, prod_lo_o} == 16'h0 && !flag_z_o && !flag_c_o && !done_o, "R9",
          $sformatf("after reset %h expected 0000", {prod_hi_o, prod_lo_o}));
    check(q.size() == 0, "R7", $sformatf("pending %0d expected 0", q.size()));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule